// File: doc/BRIEF.md
# I2C Bus Clock Divisor Pair Search

This block picks the two counts that set the bit rate of an I2C bus engine: a sample count and a step count. The bus rate that results equals the source clock divided by twice their product. Given a source clock frequency and a wanted bus frequency, the block finds the smallest product that keeps the bus at or below the wanted rate. It reports both counts minus one, ready for a timing register, and flags the cases where even the slowest setting is still too fast.

A start strobe launches a run. An iterative ceiling divider first forms the required divisor, which is half the source rate divided by the target and rounded up. A search stage then tries one sample count per clock, from 1 upward. A final stage checks whether the chosen pair really brings the rate down to the target. The outputs change only at the end of a run and are held until the next run ends.

Top module: `scl_divisor_search`

## Requirements
- R1: A target frequency above 3,400,000 Hz is treated as exactly 3,400,000 Hz for the whole run.
- R2: The sample count never exceeds 8. After clamping, the step count limit is 8 for a target above 400,000 Hz and 64 for a target of 400,000 Hz or less.
- R3: The required divisor D is ceil(floor(src/2) / target). For sample count s = 1, 2, ... 8 the candidate step count is ceil(D / s). A candidate is rejected if its step count is above the limit. It replaces the current best only if its product is strictly smaller, so on a tie the lower sample count stays.
- R4: The search stops after the first accepted candidate whose product equals D, otherwise after s = 8. With k candidates examined, done is high in the 34+k-th cycle after the cycle in which start was accepted.
- R5: When no candidate is accepted, the result is sample count 8 and step count equal to the limit.
- R6: err is 1 exactly when floor(src / (2 × sample × step)) for the chosen pair is greater than the clamped target. Equality does not raise err.
- R7: samp_m1 (3 bits) carries sample count minus one and step_m1 (6 bits) carries step count minus one.
- R8: done is high for one cycle per run. samp_m1, step_m1 and err change only together with done and hold their values between runs, whatever the inputs do.
- R9: src_hz and tgt_hz are captured when start is accepted. A start while a run is in progress is ignored and does not change that run's result or timing.
- R10: A target of 0 or a source below 2 gives err = 1 with sample count 8 and step count equal to the limit. For timing, a zero target counts as a target of 1.
- R11: After reset, samp_m1, step_m1, done and err are all 0. A reset during a run abandons it without a done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a run; accepted only when idle |
| src_hz | input | 32 | Source clock frequency in Hz |
| tgt_hz | input | 32 | Wanted bus frequency in Hz |
| samp_m1 | output | 3 | Chosen sample count minus one |
| step_m1 | output | 6 | Chosen step count minus one |
| done | output | 1 | One-cycle pulse when the result is updated |
| err | output | 1 | Chosen pair still gives a rate above the target |

## Verification
The result of a run appears together with done, 34+k cycles after the edge that accepted start. That count is 33 cycles for the divider and hand-over, k for the candidates, and one for the rate check and output register. The expected k is worked out for every vector from the search rule. The bench counts edges from the accepting edge, samples one nanosecond after each edge, and requires done to be absent at every earlier edge. It also requires done to fall on the next edge. It then changes the inputs and waits to show that the three result outputs do not move until the next run ends.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

    localparam int FREQ_W        = 32;
    localparam int SAMPLE_MAX    = 8;
    localparam int STEP_MAX_STD  = 64;
    localparam int STEP_MAX_FAST = 8;

    localparam int SAMP_W  = $clog2(SAMPLE_MAX);
    localparam int STEP_W  = $clog2(STEP_MAX_STD);
    localparam int SCNT_W  = SAMP_W + 1;
    localparam int STCNT_W = STEP_W + 1;
    localparam int PROD_MAX = SAMPLE_MAX * STEP_MAX_STD;
    localparam int PROD_W  = $clog2(PROD_MAX + 1);
    localparam int WIDE_W  = 2 * FREQ_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DIV,
        ST_SEARCH,
        ST_CHECK
    } run_state_e;

    typedef struct packed {
        logic [FREQ_W-1:0] src;
        logic [FREQ_W-1:0] tgt;
        logic              fast;
        logic              bad;
    } job_t;

    typedef struct packed {
        logic [SAMP_W-1:0] samp_m1;
        logic [STEP_W-1:0] step_m1;
        logic              err;
    } pair_result_t;

    // ceil(num / den) for a small numerator and a small nonzero divisor
    function automatic logic [PROD_W-1:0] ceil_small(
        input logic [PROD_W-1:0] num,
        input logic [SCNT_W-1:0] den
    );
        logic [PROD_W:0] sum;
        logic [PROD_W:0] den_x;
        logic [PROD_W:0] quo;
        den_x = (PROD_W+1)'(den);
        sum   = (PROD_W+1)'(num) + den_x - (PROD_W+1)'(1);
        quo   = sum / den_x;
        return PROD_W'(quo);
    endfunction

endpackage

// File: rtl/scl_div_ceil_divider.sv
module scl_div_ceil_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         valid,
    output logic [W-1:0] ceil_q
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     rem_q;
    logic [W-1:0]     quo_q;
    logic [W-1:0]     dvs_q;
    logic [CNT_W-1:0] left_q;

    logic [W:0]   shifted;
    logic         fits;
    logic [W-1:0] rem_n;
    logic [W-1:0] quo_n;
    logic [W:0]   diff;

    // one restoring step per cycle, MSB of the dividend first
    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        diff    = shifted - {1'b0, dvs_q};
        fits    = shifted >= {1'b0, dvs_q};
        rem_n   = fits ? diff[W-1:0] : shifted[W-1:0];
        quo_n   = {quo_q[W-2:0], fits};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            left_q <= '0;
            valid  <= 1'b0;
            ceil_q <= '0;
        end else if (load) begin
            rem_q  <= '0;
            quo_q  <= dividend;
            dvs_q  <= divisor;
            left_q <= CNT_W'(W);
            valid  <= 1'b0;
        end else if (left_q != '0) begin
            rem_q  <= rem_n;
            quo_q  <= quo_n;
            left_q <= left_q - CNT_W'(1);
            if (left_q == CNT_W'(1)) begin
                valid  <= 1'b1;
                ceil_q <= quo_n + W'(rem_n != '0);
            end else begin
                valid <= 1'b0;
            end
        end else begin
            valid <= 1'b0;
        end
    end

endmodule

// File: rtl/scl_div_pair_search.sv
module scl_div_pair_search
    import scl_div_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               init,
    input  logic               step_en,
    input  logic [FREQ_W-1:0]  opt_div,
    input  logic [STCNT_W-1:0] step_max,
    output logic [SCNT_W-1:0]  best_samp,
    output logic [STCNT_W-1:0] best_step,
    output logic               finish
);
    localparam logic [SCNT_W-1:0] LAST_S = SCNT_W'(SAMPLE_MAX);

    logic [SCNT_W-1:0] cur_s;
    logic [PROD_W:0]   best_prod;

    logic              in_range;
    logic [PROD_W-1:0] cand_step;
    logic [PROD_W:0]   cand_prod;
    logic              step_ok;
    logic              accept;
    logic              exact;

    // a divisor above the largest product rules out every candidate,
    // so only a PROD_W-bit numerator ever reaches the small divider
    always_comb begin
        in_range  = opt_div <= FREQ_W'(PROD_MAX);
        cand_step = ceil_small(opt_div[PROD_W-1:0], cur_s);
        cand_prod = (PROD_W+1)'(cand_step) * (PROD_W+1)'(cur_s);
        step_ok   = in_range && ((PROD_W+1)'(cand_step) <= (PROD_W+1)'(step_max));
        accept    = step_ok && (cand_prod < best_prod);
        exact     = accept && (cand_prod == (PROD_W+1)'(opt_div[PROD_W-1:0]));
        finish    = step_en && (exact || (cur_s == LAST_S));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_s     <= SCNT_W'(1);
            best_samp <= '0;
            best_step <= '0;
            best_prod <= '0;
        end else if (init) begin
            cur_s     <= SCNT_W'(1);
            best_samp <= LAST_S;
            best_step <= step_max;
            best_prod <= (PROD_W+1)'(step_max) * (PROD_W+1)'(SAMPLE_MAX);
        end else if (step_en) begin
            if (accept) begin
                best_samp <= cur_s;
                best_step <= STCNT_W'(cand_step);
                best_prod <= cand_prod;
            end
            cur_s <= cur_s + SCNT_W'(1);
        end
    end

endmodule

// File: rtl/scl_div_rate_check.sv
module scl_div_rate_check
    import scl_div_pkg::*;
(
    input  logic [FREQ_W-1:0]  src,
    input  logic [FREQ_W-1:0]  tgt,
    input  logic [SCNT_W-1:0]  samp,
    input  logic [STCNT_W-1:0] step,
    output logic               too_fast
);
    logic [WIDE_W-1:0] denom;
    logic [WIDE_W-1:0] bound;

    // floor(src/denom) > tgt  <=>  src >= (tgt+1)*denom
    always_comb begin
        denom    = WIDE_W'(samp) * WIDE_W'(step) * WIDE_W'(2);
        bound    = (WIDE_W'(tgt) + WIDE_W'(1)) * denom;
        too_fast = WIDE_W'(src) >= bound;
    end

endmodule

// File: rtl/scl_divisor_search.sv
module scl_divisor_search
    import scl_div_pkg::*;
#(
    parameter int unsigned HS_CLAMP_HZ = 3_400_000,
    parameter int unsigned FS_LIMIT_HZ = 400_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [FREQ_W-1:0] src_hz,
    input  logic [FREQ_W-1:0] tgt_hz,
    output logic [SAMP_W-1:0] samp_m1,
    output logic [STEP_W-1:0] step_m1,
    output logic              done,
    output logic              err
);
    localparam logic [FREQ_W-1:0] CLAMP_V = FREQ_W'(HS_CLAMP_HZ);
    localparam logic [FREQ_W-1:0] FS_V    = FREQ_W'(FS_LIMIT_HZ);

    run_state_e         state_q;
    job_t               job_d;
    job_t               job_q;
    pair_result_t       res_d;
    pair_result_t       res_q;
    logic               done_q;
    logic               busy;
    logic               take;
    logic               div_valid;
    logic               srch_init;
    logic               srch_step;
    logic               srch_finish;
    logic               too_fast;
    logic [FREQ_W-1:0]  tgt_clamped;
    logic [FREQ_W-1:0]  opt_div;
    logic [STCNT_W-1:0] step_max;
    logic [STCNT_W-1:0] best_step;
    logic [SCNT_W-1:0]  best_samp;

    assign busy = state_q != ST_IDLE;
    assign take = start && !busy;

    // job capture: clamp, speed mode and degenerate inputs
    always_comb begin
        tgt_clamped = (tgt_hz > CLAMP_V) ? CLAMP_V : tgt_hz;
        job_d.src   = src_hz;
        job_d.tgt   = (tgt_hz == '0) ? FREQ_W'(1) : tgt_clamped;
        job_d.fast  = tgt_clamped > FS_V;
        job_d.bad   = (tgt_hz == '0) || (src_hz < FREQ_W'(2));
    end

    assign step_max  = job_q.fast ? STCNT_W'(STEP_MAX_FAST) : STCNT_W'(STEP_MAX_STD);
    assign srch_init = (state_q == ST_DIV) && div_valid;
    assign srch_step = state_q == ST_SEARCH;

    scl_div_ceil_divider #(
        .W (FREQ_W)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .load     (take),
        .dividend (src_hz >> 1),
        .divisor  (job_d.tgt),
        .valid    (div_valid),
        .ceil_q   (opt_div)
    );

    scl_div_pair_search u_search (
        .clk       (clk),
        .rst       (rst),
        .init      (srch_init),
        .step_en   (srch_step),
        .opt_div   (opt_div),
        .step_max  (step_max),
        .best_samp (best_samp),
        .best_step (best_step),
        .finish    (srch_finish)
    );

    scl_div_rate_check u_check (
        .src      (job_q.src),
        .tgt      (job_q.tgt),
        .samp     (best_samp),
        .step     (best_step),
        .too_fast (too_fast)
    );

    always_comb begin
        if (job_q.bad) begin
            res_d.samp_m1 = SAMP_W'(SAMPLE_MAX - 1);
            res_d.step_m1 = STEP_W'(step_max - STCNT_W'(1));
            res_d.err     = 1'b1;
        end else begin
            res_d.samp_m1 = SAMP_W'(best_samp - SCNT_W'(1));
            res_d.step_m1 = STEP_W'(best_step - STCNT_W'(1));
            res_d.err     = too_fast;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            job_q   <= '0;
            res_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        job_q   <= job_d;
                        state_q <= ST_DIV;
                    end
                end
                ST_DIV: begin
                    if (div_valid) begin
                        state_q <= ST_SEARCH;
                    end
                end
                ST_SEARCH: begin
                    if (srch_finish) begin
                        state_q <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    res_q   <= res_d;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign samp_m1 = res_q.samp_m1;
    assign step_m1 = res_q.step_m1;
    assign err     = res_q.err;
    assign done    = done_q;

endmodule

// File: rtl/scl_divisor_search_checker.sv
module scl_divisor_search_checker
    import scl_div_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               done,
    input logic               err,
    input logic [SAMP_W-1:0]  samp_m1,
    input logic [STEP_W-1:0]  step_m1,
    input logic               busy,
    input logic [STCNT_W-1:0] step_max,
    input logic [FREQ_W-1:0]  run_src,
    input logic [FREQ_W-1:0]  run_tgt
);

    // R8: done lasts a single cycle
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: results move only with done
    p_hold_outputs_r8: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(rst)) |-> ($stable(samp_m1) && $stable(step_m1) && $stable(err)));

    // R2: reported step count stays within the limit of the speed mode
    p_step_limit_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> ({1'b0, step_m1} < step_max));

    // R9: captured inputs stay fixed while a run is in progress
    p_job_latched_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(run_src) && $stable(run_tgt)));

    // R4: done only closes a run that was in progress
    p_done_after_run_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

endmodule

bind scl_divisor_search scl_divisor_search_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .err      (err),
    .samp_m1  (samp_m1),
    .step_m1  (step_m1),
    .busy     (busy),
    .step_max (step_max),
    .run_src  (job_q.src),
    .run_tgt  (job_q.tgt)
);

// File: tb/scl_divisor_search_bench.sv
`timescale 1ns/1ps
module scl_divisor_search_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] src_hz = '0;
    logic [31:0] tgt_hz = '0;
    logic [2:0]  samp_m1;
    logic [5:0]  step_m1;
    logic        done;
    logic        err;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    scl_divisor_search u_scl_divisor_search (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .src_hz  (src_hz),
        .tgt_hz  (tgt_hz),
        .samp_m1 (samp_m1),
        .step_m1 (step_m1),
        .done    (done),
        .err     (err)
    );

    // {src, tgt, samp_m1, step_m1, err, k}
    localparam int NV = 12;
    localparam logic [77:0] VECS [NV] = '{
        {32'd100000000, 32'd100000,  3'd7, 6'd62, 1'b0, 4'd8}, // R3 search to s=8
        {32'd100000000, 32'd400000,  3'd4, 6'd24, 1'b0, 4'd5}, // R2 R3 std limit at boundary
        {32'd100000000, 32'd1000000, 3'd6, 6'd7,  1'b0, 4'd8}, // R2 fast limit, R3 tie keeps s=7
        {32'd100000000, 32'd5000000, 3'd2, 6'd4,  1'b0, 4'd3}, // R1 clamp
        {32'd100000000, 32'd3400000, 3'd2, 6'd4,  1'b0, 4'd3}, // R1 exactly at clamp
        {32'd100000000, 32'd10000,   3'd7, 6'd63, 1'b1, 4'd8}, // R5 R6
        {32'd20000000,  32'd400000,  3'd0, 6'd24, 1'b0, 4'd1}, // R4 early stop at s=1
        {32'd100000000, 32'd400001,  3'd7, 6'd7,  1'b1, 4'd8}, // R2 R5 fast defaults
        {32'd1024000,   32'd1000,    3'd7, 6'd63, 1'b0, 4'd8}, // R6 equality no err
        {32'd1025024,   32'd1000,    3'd7, 6'd63, 1'b1, 4'd8}, // R6 just above
        {32'd100000000, 32'd0,       3'd7, 6'd63, 1'b1, 4'd8}, // R10 zero target
        {32'd1,         32'd100000,  3'd7, 6'd63, 1'b1, 4'd1}  // R10 tiny source
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // runs one job; poke=1 fires a second start mid-run with other inputs
    task automatic run_job(input logic [31:0] s, input logic [31:0] t,
                           input logic [2:0] es, input logic [5:0] est,
                           input logic ee, input int k, input bit poke,
                           input string tag);
        int got;
        got = 0;
        src_hz = s;
        tgt_hz = t;
        start  = 1'b1;
        @(posedge clk);
        #1;
        start  = 1'b0;
        src_hz = 32'd12345;     // scrambled after capture (R9)
        tgt_hz = 32'd777;
        for (int i = 1; i <= 80; i++) begin
            if (poke && i == 10) begin
                start  = 1'b1;
                src_hz = 32'd100000000;
                tgt_hz = 32'd400001;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            #1;
            if (done) begin
                got = i;
                break;
            end
        end
        start = 1'b0;
        chk({tag, " R4 latency"}, got, 34 + k);
        chk({tag, " R7 samp_m1"}, {29'd0, samp_m1}, {29'd0, es});
        chk({tag, " R7 step_m1"}, {26'd0, step_m1}, {26'd0, est});
        chk({tag, " R6 err"}, {31'd0, err}, {31'd0, ee});
        @(posedge clk);
        #1;
        chk({tag, " R8 done pulse"}, {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        chk("R11 samp", {29'd0, samp_m1}, 32'd0);
        chk("R11 step", {26'd0, step_m1}, 32'd0);
        chk("R11 done", {31'd0, done}, 32'd0);
        chk("R11 err",  {31'd0, err}, 32'd0);
        rst = 1'b0;
        @(posedge clk);
        #1;

        for (int v = 0; v < NV; v++) begin
            run_job(VECS[v][77:46], VECS[v][45:14], VECS[v][13:11],
                    VECS[v][10:5], VECS[v][4], int'(VECS[v][3:0]), 1'b0,
                    $sformatf("vec%0d", v));
        end

        // R9: second start during a run is ignored
        run_job(32'd100000000, 32'd100000, 3'd7, 6'd62, 1'b0, 8, 1'b1, "r9_ignore");

        // R8: outputs hold while inputs change and no start comes
        src_hz = 32'd20000000;
        tgt_hz = 32'd400000;
        repeat (20) @(posedge clk);
        #1;
        chk("R8 hold samp", {29'd0, samp_m1}, 32'd7);
        chk("R8 hold step", {26'd0, step_m1}, 32'd62);
        chk("R8 hold err",  {31'd0, err}, 32'd0);

        // R11: reset mid-run abandons it
        src_hz = 32'd20000000;
        tgt_hz = 32'd400000;
        start  = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
        repeat (5) @(posedge clk);
        #1;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 50; i++) begin
                @(posedge clk);
                #1;
                if (done) seen++;
            end
            chk("R11 no done after abort", seen, 0);
        end
        chk("R11 samp after abort", {29'd0, samp_m1}, 32'd0);
        chk("R11 step after abort", {26'd0, step_m1}, 32'd0);
        chk("R11 err after abort",  {31'd0, err}, 32'd0);

        // recovery after the abort
        run_job(32'd100000000, 32'd5000000, 3'd2, 6'd4, 1'b0, 3, 1'b0, "r1_recover");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule